// File: doc/BRIEF.md
# I2C Bus Recovery Line Sequencer

This block frees an I2C bus that a slave has wedged by holding SDA low part-way through a byte. When triggered, it takes both open-drain lines away from the byte engine and clocks SCL low nine times while leaving SDA free, so the slave can shift out the rest of its byte and let go. It then builds a STOP condition by hand: both lines are pulled low, SCL is let go while SDA is still held, and finally both lines are let go. Each step of the sequence lasts a fixed number of system clock cycles, set by a parameter, and a one-cycle done pulse marks the end.

Outside a recovery, the block passes the byte engine's pull-low requests to the lines, combined with two manual force bits held in a small override register. The same register returns the synchronized live levels of both lines, so software can see whether the bus has come free. Deciding when a recovery is needed is left to the logic around the block.

Top module: `i2c_line_rescue`

## Requirements
- R1: After reset, neither line is pulled low, busy and done are 0, both force bits read 0 and both live-level bits read 1.
- R2: A trigger accepted while idle sets busy from the next cycle, and the sequence begins with PULSES (default 9) repetitions of one phase with both lines free followed by one phase with only SCL pulled low; SDA is never pulled low during this train.
- R3: After the train come three phases: both lines pulled low, then SCL free with SDA still pulled low, then both lines free.
- R4: Every phase lasts exactly PHASE_CYC system clock cycles, so busy stays high for (2*PULSES+3)*PHASE_CYC cycles.
- R5: done is a single-cycle pulse in the first cycle after the last phase, the same cycle in which busy falls.
- R6: While busy, the line controls follow only the sequence; the force bits and the byte engine's requests have no effect on them.
- R7: A trigger that arrives while busy, including in the last cycle of the last phase, is ignored: the running sequence neither restarts nor lengthens and no new sequence follows it.
- R8: A register write copies write-data bit 8 into the SDA force bit and bit 9 into the SCL force bit; these bits read back at the same positions and, while idle, pull the matching line low from the cycle after the write.
- R9: Read bit 10 gives the live SDA level and bit 11 the live SCL level, each delayed by SYNC_STAGES clock edges; all other read bits are 0.
- R10: While idle, each line is pulled low exactly when its force bit or the byte engine's request for that line is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Recovery trigger, sampled on the clock edge |
| reg_wr_i | input | 1 | Override register write strobe |
| reg_wdata_i | input | REG_W | Override register write data |
| reg_rdata_o | output | REG_W | Override register read data: force bits and live levels |
| eng_scl_low_i | input | 1 | Byte engine request to pull SCL low |
| eng_sda_low_i | input | 1 | Byte engine request to pull SDA low |
| scl_i | input | 1 | Live SCL pad level |
| sda_i | input | 1 | Live SDA pad level |
| scl_oe_o | output | 1 | Pull SCL low (open-drain enable) |
| sda_oe_o | output | 1 | Pull SDA low (open-drain enable) |
| busy_o | output | 1 | Recovery sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a recovery |

## Verification
Two functions can fall in the same cycle: a fresh trigger and the sequencer's own return to idle at the end of the last release phase, and likewise a manual force write or engine request and a cycle where the sequencer owns the lines. The bench raises the trigger once mid-train and once in the very last busy cycle, with both force bits and both engine requests held active throughout, and judges the result by checking the line pattern cycle by cycle against the phase schedule, done arriving exactly (2*PULSES+3)*PHASE_CYC cycles after the first trigger, busy staying low afterwards, and the lines returning to the forced level once idle.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

   typedef enum logic [2:0] {
      RS_IDLE      = 3'd0,
      RS_TRAIN     = 3'd1,
      RS_STOP_BOTH = 3'd2,
      RS_STOP_SDA  = 3'd3,
      RS_RELEASE   = 3'd4
   } rs_state_e;

   // line index inside two-bit line vectors
   localparam int unsigned LN_SDA = 0;
   localparam int unsigned LN_SCL = 1;
   localparam int unsigned LN_NUM = 2;

   // override register field positions (software decodes these)
   localparam int unsigned OVR_SDA_BIT  = 8;
   localparam int unsigned OVR_SCL_BIT  = 9;
   localparam int unsigned LIVE_SDA_BIT = 10;
   localparam int unsigned LIVE_SCL_BIT = 11;
   localparam int unsigned REG_MIN_W    = 12;

endpackage

// File: rtl/lrs_phase_timer.sv
module lrs_phase_timer #(
   parameter int unsigned PHASE_CYC = 625
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic run_i,
   output logic expire_o
);
   localparam int unsigned CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
   localparam logic [CW-1:0] LOAD = CW'(PHASE_CYC - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (arm_i) begin
         cnt_q <= LOAD;
      end else if (run_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/lrs_sequencer.sv
module lrs_sequencer
   import lrs_pkg::*;
#(
   parameter int unsigned PULSES = 9
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      trig_i,
   input  logic      expire_i,
   output logic      arm_o,
   output logic      busy_o,
   output logic      done_o,
   output logic      scl_low_o,
   output logic      sda_low_o,
   output rs_state_e state_o
);
   localparam int unsigned PW = (PULSES > 1) ? $clog2(PULSES) : 1;
   localparam logic [PW-1:0] LAST = PW'(PULSES - 1);

   rs_state_e     state_q;
   logic          half_q;   // 0: lines free, 1: SCL low
   logic [PW-1:0] pcnt_q;
   logic          done_q;
   logic          accept;

   assign accept = (state_q == RS_IDLE) && trig_i;
   assign arm_o  = accept || expire_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RS_IDLE;
         half_q  <= 1'b0;
         pcnt_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state_q <= RS_TRAIN;
            half_q  <= 1'b0;
            pcnt_q  <= '0;
         end else if (expire_i) begin
            case (state_q)
               RS_TRAIN: begin
                  if (!half_q) begin
                     half_q <= 1'b1;
                  end else if (pcnt_q == LAST) begin
                     half_q  <= 1'b0;
                     state_q <= RS_STOP_BOTH;
                  end else begin
                     half_q <= 1'b0;
                     pcnt_q <= pcnt_q + 1'b1;
                  end
               end
               RS_STOP_BOTH: state_q <= RS_STOP_SDA;
               RS_STOP_SDA:  state_q <= RS_RELEASE;
               RS_RELEASE: begin
                  state_q <= RS_IDLE;
                  done_q  <= 1'b1;
               end
               default: state_q <= RS_IDLE;
            endcase
         end
      end
   end

   assign busy_o    = (state_q != RS_IDLE);
   assign done_o    = done_q;
   assign scl_low_o = ((state_q == RS_TRAIN) && half_q) || (state_q == RS_STOP_BOTH);
   assign sda_low_o = (state_q == RS_STOP_BOTH) || (state_q == RS_STOP_SDA);
   assign state_o   = state_q;

endmodule

// File: rtl/lrs_sync.sv
module lrs_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stg_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stg_q[s] <= '1;   // idle bus reads high
               end else if (s == 0) begin
                  stg_q[s] <= d_i;
               end else begin
                  stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
               end
            end
         end
         assign q_o = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lrs_ovr_reg.sv
module lrs_ovr_reg
   import lrs_pkg::*;
#(
   parameter int unsigned REG_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [REG_W-1:0]  wdata_i,
   input  logic [LN_NUM-1:0] live_i,
   output logic [LN_NUM-1:0] force_o,
   output logic [REG_W-1:0]  rdata_o
);
   logic [LN_NUM-1:0] force_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_q <= '0;
      end else if (wr_i) begin
         force_q[LN_SDA] <= wdata_i[OVR_SDA_BIT];
         force_q[LN_SCL] <= wdata_i[OVR_SCL_BIT];
      end
   end

   always_comb begin
      rdata_o               = '0;
      rdata_o[OVR_SDA_BIT]  = force_q[LN_SDA];
      rdata_o[OVR_SCL_BIT]  = force_q[LN_SCL];
      rdata_o[LIVE_SDA_BIT] = live_i[LN_SDA];
      rdata_o[LIVE_SCL_BIT] = live_i[LN_SCL];
   end

   assign force_o = force_q;

endmodule

// File: rtl/i2c_line_rescue.sv
module i2c_line_rescue
   import lrs_pkg::*;
#(
   parameter int unsigned PHASE_CYC   = 625,
   parameter int unsigned PULSES      = 9,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REG_W       = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             reg_wr_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   output logic [REG_W-1:0] reg_rdata_o,
   input  logic             eng_scl_low_i,
   input  logic             eng_sda_low_i,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             scl_oe_o,
   output logic             sda_oe_o,
   output logic             busy_o,
   output logic             done_o
);
   // elaboration-time parameter checks
   generate
      if (PHASE_CYC < 1) begin : g_bad_phase
         $error("PHASE_CYC must be at least 1");
      end
      if (PULSES < 1) begin : g_bad_pulses
         $error("PULSES must be at least 1");
      end
      if (REG_W < REG_MIN_W) begin : g_bad_regw
         $error("REG_W too small for the override register fields");
      end
   endgenerate

   logic              expire;
   logic              arm;
   logic              seq_busy;
   logic              seq_scl_low;
   logic              seq_sda_low;
   rs_state_e         seq_state;
   logic [LN_NUM-1:0] seq_low;
   logic [LN_NUM-1:0] eng_low;
   logic [LN_NUM-1:0] force_low;
   logic [LN_NUM-1:0] pad_lvl;
   logic [LN_NUM-1:0] live_lvl;
   logic [LN_NUM-1:0] line_oe;

   lrs_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (arm),
      .run_i    (seq_busy),
      .expire_o (expire)
   );

   lrs_sequencer #(.PULSES(PULSES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_i    (start_i),
      .expire_i  (expire),
      .arm_o     (arm),
      .busy_o    (seq_busy),
      .done_o    (done_o),
      .scl_low_o (seq_scl_low),
      .sda_low_o (seq_sda_low),
      .state_o   (seq_state)
   );

   assign pad_lvl[LN_SDA] = sda_i;
   assign pad_lvl[LN_SCL] = scl_i;

   lrs_sync #(.STAGES(SYNC_STAGES), .W(LN_NUM)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pad_lvl),
      .q_o   (live_lvl)
   );

   lrs_ovr_reg #(.REG_W(REG_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr_i),
      .wdata_i (reg_wdata_i),
      .live_i  (live_lvl),
      .force_o (force_low),
      .rdata_o (reg_rdata_o)
   );

   assign seq_low[LN_SDA] = seq_sda_low;
   assign seq_low[LN_SCL] = seq_scl_low;
   assign eng_low[LN_SDA] = eng_sda_low_i;
   assign eng_low[LN_SCL] = eng_scl_low_i;

   // per-line ownership: sequencer while busy, else manual force or engine
   generate
      for (genvar ln = 0; ln < LN_NUM; ln++) begin : g_line
         assign line_oe[ln] = seq_busy ? seq_low[ln] : (force_low[ln] | eng_low[ln]);
      end
   endgenerate

   assign sda_oe_o = line_oe[LN_SDA];
   assign scl_oe_o = line_oe[LN_SCL];
   assign busy_o   = seq_busy;

endmodule

// File: rtl/i2c_line_rescue_chk.sv
module i2c_line_rescue_chk
   import lrs_pkg::*;
#(
   parameter int unsigned PHASE_CYC = 625
) (
   input logic      clk,
   input logic      rst_n,
   input logic      start_i,
   input logic      scl_oe_o,
   input logic      sda_oe_o,
   input logic      busy_o,
   input logic      done_o,
   input rs_state_e state
);
   localparam int unsigned LW = $clog2(PHASE_CYC + 2) + 1;

   logic [1:0]    prev_pat;
   logic          prev_busy;
   logic [LW-1:0] run_len;
   logic          pat_chg;

   assign pat_chg = ({scl_oe_o, sda_oe_o} != prev_pat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_pat  <= '0;
         prev_busy <= 1'b0;
         run_len   <= '0;
      end else begin
         prev_pat  <= {scl_oe_o, sda_oe_o};
         prev_busy <= busy_o;
         if (!busy_o)      run_len <= '0;
         else if (pat_chg && prev_busy) run_len <= LW'(1);
         else              run_len <= run_len + 1'b1;
      end
   end

   p_sda_free_train_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RS_TRAIN) |-> !sda_oe_o);

   p_stop_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $fell(scl_oe_o) && sda_oe_o) |-> $past(sda_oe_o));

   p_stop_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RS_STOP_SDA) |-> (sda_oe_o && !scl_oe_o));

   p_phase_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && prev_busy && pat_chg) |-> (run_len == LW'(PHASE_CYC)));

   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   p_retrig_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && (state != RS_RELEASE)) |=> (busy_o && !done_o));

endmodule

bind i2c_line_rescue i2c_line_rescue_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .scl_oe_o (scl_oe_o),
   .sda_oe_o (sda_oe_o),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .state    (seq_state)
);

// File: tb/i2c_line_rescue_tb_top.sv
`timescale 1ns/1ps
module i2c_line_rescue_tb_top;
   localparam int unsigned P     = 4;
   localparam int unsigned NP    = 9;
   localparam int unsigned SYNC  = 2;
   localparam int unsigned RW    = 12;
   localparam int unsigned TOT   = (2*NP + 3) * P;

   // idle mux vectors: {force_sda, force_scl, eng_sda, eng_scl, exp_sda_oe, exp_scl_oe}
   localparam logic [5:0] VEC [8] = '{
      6'b00_00_00, 6'b01_00_01, 6'b10_00_10, 6'b00_01_01,
      6'b00_10_10, 6'b11_00_11, 6'b00_11_11, 6'b10_01_11
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          reg_wr = 1'b0;
   logic [RW-1:0] reg_wdata = '0;
   logic [RW-1:0] reg_rdata;
   logic          eng_scl = 1'b0, eng_sda = 1'b0;
   logic          hold_scl = 1'b0, hold_sda = 1'b0;
   logic          scl_oe, sda_oe, busy, done;
   logic          scl_pad, sda_pad;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   assign scl_pad = !(scl_oe | hold_scl);
   assign sda_pad = !(sda_oe | hold_sda);

   i2c_line_rescue #(.PHASE_CYC(P), .PULSES(NP), .SYNC_STAGES(SYNC), .REG_W(RW)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start),
      .reg_wr_i      (reg_wr),
      .reg_wdata_i   (reg_wdata),
      .reg_rdata_o   (reg_rdata),
      .eng_scl_low_i (eng_scl),
      .eng_sda_low_i (eng_sda),
      .scl_i         (scl_pad),
      .sda_i         (sda_pad),
      .scl_oe_o      (scl_oe),
      .sda_oe_o      (sda_oe),
      .busy_o        (busy),
      .done_o        (done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr_force(input logic fsda, input logic fscl);
      reg_wdata = '0;
      reg_wdata[8] = fsda;
      reg_wdata[9] = fscl;
      reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // full recovery run; retrig adds triggers mid-train and in the last busy cycle
   task automatic run_seq(input bit retrig, input logic [1:0] exp_idle);
      logic [1:0] exp;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 1; c <= int'(TOT); c++) begin
         int k;
         k = (c - 1) / int'(P);
         if (k < int'(2*NP))             exp = (k % 2 == 1) ? 2'b10 : 2'b00; // {scl,sda}
         else if (k == int'(2*NP))       exp = 2'b11;
         else if (k == int'(2*NP) + 1)   exp = 2'b01;
         else                            exp = 2'b00;
         if (k < int'(2*NP)) chk(retrig ? "R2/R4/R6 train" : "R2/R4 train", {30'd0, scl_oe, sda_oe}, {30'd0, exp});
         else                chk(retrig ? "R3/R4/R6 stop" : "R3/R4 stop", {30'd0, scl_oe, sda_oe}, {30'd0, exp});
         chk(retrig ? "R7 busy held" : "R4 busy held", {30'd0, busy, done}, 32'h2);
         start = retrig && (c == 7 || c == int'(TOT));
         @(negedge clk);
      end
      start = 1'b0;
      chk("R5 done pulse with busy low", {30'd0, busy, done}, 32'h1);
      chk(retrig ? "R7 idle lines after run" : "R10 idle lines after run", {30'd0, scl_oe, sda_oe}, {30'd0, exp_idle});
      @(negedge clk);
      chk(retrig ? "R7 no restart" : "R5 done single", {30'd0, busy, done}, 32'h0);
      repeat (3) @(negedge clk);
      chk("R7 still idle", {31'd0, busy}, 32'h0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
         $finish;
      end
   end

   initial begin : main
      // R1 reset state, during and after reset
      repeat (3) @(negedge clk);
      chk("R1 lines in reset", {30'd0, scl_oe, sda_oe}, 32'h0);
      chk("R1 busy/done in reset", {30'd0, busy, done}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 register after reset", {20'd0, reg_rdata}, 32'hC00);
      chk("R1 lines after reset", {30'd0, scl_oe, sda_oe}, 32'h0);

      // R9 live level read-back with synchronizer latency
      hold_sda = 1'b1;
      @(negedge clk);
      chk("R9 sda not yet visible", {20'd0, reg_rdata}, 32'hC00);
      @(negedge clk);
      chk("R9 live sda low", {20'd0, reg_rdata}, 32'h800);
      hold_sda = 1'b0;
      hold_scl = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9 live scl low", {20'd0, reg_rdata}, 32'h400);
      hold_scl = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 both live high", {20'd0, reg_rdata}, 32'hC00);

      // R8 write force bits, read-back timing
      wr_force(1'b1, 1'b1);
      chk("R8 force bits immediate", {20'd0, reg_rdata}, 32'hF00);
      chk("R8 force lines low", {30'd0, scl_oe, sda_oe}, 32'h3);
      repeat (2) @(negedge clk);
      chk("R8/R9 forced lines read low", {20'd0, reg_rdata}, 32'h300);

      // R10 idle mux table walk
      for (int i = 0; i < 8; i++) begin
         logic [5:0] v;
         v = VEC[i];
         eng_sda = v[3];
         eng_scl = v[2];
         wr_force(v[5], v[4]);
         chk("R10 idle sda", {31'd0, sda_oe}, {31'd0, v[1]});
         chk("R10 idle scl", {31'd0, scl_oe}, {31'd0, v[0]});
         chk("R8 force read-back", {30'd0, reg_rdata[9:8]}, {30'd0, v[4], v[5]});
      end
      eng_sda = 1'b0;
      eng_scl = 1'b0;
      wr_force(1'b0, 1'b0);
      repeat (3) @(negedge clk);

      // clean recovery run
      run_seq(1'b0, 2'b00);

      // run with overrides active and repeated triggers
      wr_force(1'b1, 1'b1);
      eng_sda = 1'b1;
      eng_scl = 1'b1;
      @(negedge clk);
      run_seq(1'b1, 2'b11);

      eng_sda = 1'b0;
      eng_scl = 1'b0;
      wr_force(1'b0, 1'b0);
      repeat (SYNC + 1) @(negedge clk);
      chk("R8/R9 cleared register", {20'd0, reg_rdata}, 32'hC00);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   end

endmodule